// File: doc/BRIEF.md
# Swallow-Count Programmable Divider

This block divides a fast clock by a programmable integer N and emits one pulse per N input cycles, ready for a phase comparator. Inside, a stage that counts in eights or nines is steered by a small swallow count and a larger main count. This gives N = 8M + A from a single 15-bit ratio word, where M is the upper twelve bits and A is the lower three. Because every integer in the legal range can be reached, the tuning step equals the comparison rate.

A new ratio word is presented with a one-cycle strobe. It is held aside and takes effect only when the division cycle in progress has finished, so no cycle is ever cut short or stretched. A word below the smallest ratio the structure can produce is raised to that minimum, and a flag reports it. A test selection routes the divider output, divided by two, to a general-purpose output that otherwise carries ordinary port data.

Top module: `swallow_divider`

## Requirements
- R1: The ratio word splits into A = bits 2..0 and M = bits 14..3, and the interval between successive rising edges of `div_pulse` equals 8M + A clock cycles for every legal word up to 32767.
- R2: `div_pulse` is high for exactly one clock cycle per division cycle.
- R3: A word below 56 loaded with `ratio_load` gives a ratio of 56 and sets `range_err` one cycle after the strobe. A word of 56 or more clears `range_err` at the same point.
- R4: A word loaded during a division cycle does not change that cycle's length. The new ratio governs the cycle that starts after the next `div_pulse`.
- R5: With `test_mode` = 2'b01, `p0_out` carries a divide-by-two of the divider output: it inverts at each `div_pulse` and holds between pulses. For any other `test_mode` value, `p0_out` equals `p0_data`.
- R6: While `rst` is high, `div_pulse` and `range_err` are 0 and the half-rate state is 0. After reset the ratio is the parameter `RST_RATIO`, which defaults to 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| ratio_word | input | 15 | Requested ratio; bits 14..3 are M, bits 2..0 are A |
| ratio_load | input | 1 | One-cycle strobe that captures `ratio_word` |
| test_mode | input | 2 | 2'b01 selects the half-rate tap on `p0_out` |
| p0_data | input | 1 | Ordinary port data for `p0_out` |
| div_pulse | output | 1 | One-cycle pulse per N input cycles |
| p0_out | output | 1 | Port output: `p0_data` or the half-rate tap |
| range_err | output | 1 | Last loaded word was below the minimum ratio |

## Verification
The bench builds the block with its default widths: three swallow bits, twelve main bits, a minimum of 56 and a reset ratio of 100. These values allow checks at the exact floor, at points where the swallow count is zero or at its maximum of seven, and at the full 15-bit ceiling of 32767. The ceiling costs about 33 thousand cycles per measured period. Loading a word mid-cycle against a known current ratio shows that a change is deferred to the next cycle boundary.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
    localparam int SWL_W    = 3;
    localparam int MAIN_W   = 12;
    localparam int WORD_W   = SWL_W + MAIN_W;
    localparam int PRE_BASE = 1 << SWL_W;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic [MAIN_W-1:0] main_cnt;
        logic [SWL_W-1:0]  swallow;
    } ratio_t;

    typedef enum logic [1:0] {
        TM_NORMAL   = 2'b00,
        TM_HALF_TAP = 2'b01,
        TM_OTHER_A  = 2'b10,
        TM_OTHER_B  = 2'b11
    } tmode_e;

    function automatic ratio_t clamp_ratio(word_t w, word_t floor_w);
        return ratio_t'((w < floor_w) ? floor_w : w);
    endfunction
endpackage

// File: rtl/swdiv_ratio_load.sv
module swdiv_ratio_load
    import swdiv_pkg::*;
#(
    parameter int MIN_RATIO = 56,
    parameter int RST_RATIO = 100
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  word_t  word_in,
    input  logic   cycle_end,
    output ratio_t next_ratio,
    output logic   range_err
);
    localparam word_t FLOOR_W = word_t'(MIN_RATIO);
    localparam word_t RESET_W = word_t'(RST_RATIO);

    ratio_t pend_q;
    ratio_t cur_q;
    logic   pend_v;

    assign next_ratio = pend_v ? pend_q : cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= ratio_t'(RESET_W);
            cur_q     <= ratio_t'(RESET_W);
            pend_v    <= 1'b0;
            range_err <= 1'b0;
        end else begin
            if (cycle_end) begin
                cur_q <= next_ratio;
                if (!load) pend_v <= 1'b0;
            end
            if (load) begin
                pend_q    <= clamp_ratio(word_in, FLOOR_W);
                pend_v    <= 1'b1;
                range_err <= (word_in < FLOOR_W);
            end
        end
    end
endmodule

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler
    import swdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic use_nine,
    output logic tc
);
    localparam logic [SWL_W:0] LAST_NINE  = PRE_BASE[SWL_W:0];
    localparam logic [SWL_W:0] LAST_EIGHT = LAST_NINE - (SWL_W+1)'(1);

    logic [SWL_W:0] pc;

    assign tc = (pc == (use_nine ? LAST_NINE : LAST_EIGHT));

    always_ff @(posedge clk) begin
        if (rst || tc) pc <= '0;
        else           pc <= pc + (SWL_W+1)'(1);
    end
endmodule

// File: rtl/swdiv_cycle_ctl.sv
module swdiv_cycle_ctl
    import swdiv_pkg::*;
#(
    parameter int RST_RATIO = 100
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tc,
    input  ratio_t reload,
    output logic   use_nine,
    output logic   cycle_end
);
    localparam ratio_t RESET_R = ratio_t'(word_t'(RST_RATIO));

    logic [MAIN_W-1:0] mc;
    logic [SWL_W-1:0]  ac;

    assign use_nine  = (ac != '0);
    assign cycle_end = tc && (mc == MAIN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            mc <= RESET_R.main_cnt;
            ac <= RESET_R.swallow;
        end else if (cycle_end) begin
            mc <= reload.main_cnt;
            ac <= reload.swallow;
        end else if (tc) begin
            mc <= mc - MAIN_W'(1);
            if (use_nine) ac <= ac - SWL_W'(1);
        end
    end
endmodule

// File: rtl/swdiv_tap.sv
module swdiv_tap
    import swdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cycle_end,
    input  logic [1:0] test_mode,
    input  logic       p0_data,
    output logic       div_pulse,
    output logic       p0_out
);
    logic half_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_pulse <= 1'b0;
            half_q    <= 1'b0;
        end else begin
            div_pulse <= cycle_end;
            half_q    <= half_q ^ cycle_end;
        end
    end

    assign p0_out = (tmode_e'(test_mode) == TM_HALF_TAP) ? half_q : p0_data;
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
    import swdiv_pkg::*;
#(
    parameter int MIN_RATIO = 56,
    parameter int RST_RATIO = 100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [14:0] ratio_word,
    input  logic        ratio_load,
    input  logic [1:0]  test_mode,
    input  logic        p0_data,
    output logic        div_pulse,
    output logic        p0_out,
    output logic        range_err
);
    ratio_t next_ratio;
    logic   use_nine;
    logic   tc;
    logic   cycle_end;

    swdiv_ratio_load #(.MIN_RATIO(MIN_RATIO), .RST_RATIO(RST_RATIO)) u_load (
        .clk(clk), .rst(rst), .load(ratio_load), .word_in(word_t'(ratio_word)),
        .cycle_end(cycle_end), .next_ratio(next_ratio), .range_err(range_err)
    );

    swdiv_prescaler u_pre (
        .clk(clk), .rst(rst), .use_nine(use_nine), .tc(tc)
    );

    swdiv_cycle_ctl #(.RST_RATIO(RST_RATIO)) u_ctl (
        .clk(clk), .rst(rst), .tc(tc), .reload(next_ratio),
        .use_nine(use_nine), .cycle_end(cycle_end)
    );

    swdiv_tap u_tap (
        .clk(clk), .rst(rst), .cycle_end(cycle_end), .test_mode(test_mode),
        .p0_data(p0_data), .div_pulse(div_pulse), .p0_out(p0_out)
    );
endmodule

// File: rtl/swallow_divider_chk.sv
module swallow_divider_chk #(
    parameter int MIN_RATIO = 56
) (
    input logic        clk,
    input logic        rst,
    input logic [14:0] ratio_word,
    input logic        ratio_load,
    input logic [1:0]  test_mode,
    input logic        p0_data,
    input logic        div_pulse,
    input logic        p0_out,
    input logic        range_err
);
    logic [15:0] gap;
    logic        seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (div_pulse) begin
            gap  <= 16'd1;
            seen <= 1'b1;
        end else begin
            gap <= gap + 16'd1;
        end
    end

    // R2: pulse lasts a single cycle
    p_one_wide_r2: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);

    // R1: no division cycle is shorter than the floor
    p_min_gap_r1: assert property (@(posedge clk) disable iff (rst)
        (div_pulse && seen) |-> (gap >= 16'(MIN_RATIO)));

    // R3: flag follows the word captured by the strobe
    p_clamp_flag_r3: assert property (@(posedge clk) disable iff (rst)
        ratio_load |=> (range_err == ($past(ratio_word) < 15'(MIN_RATIO))));

    // R5: half-rate tap inverts at each pulse
    p_tap_flip_r5: assert property (@(posedge clk) disable iff (rst)
        (div_pulse && test_mode == 2'b01 && $past(test_mode) == 2'b01)
            |-> (p0_out != $past(p0_out)));

    // R5: other modes pass the port data
    p_pass_r5: assert property (@(posedge clk) disable iff (rst)
        (test_mode != 2'b01) |-> (p0_out == p0_data));

    // R6: outputs quiet after a reset cycle
    p_reset_quiet_r6: assert property (@(posedge clk)
        rst |=> (!div_pulse && !range_err));
endmodule

bind swallow_divider swallow_divider_chk #(.MIN_RATIO(MIN_RATIO)) u_chk (.*);

// File: tb/sim_swallow_divider.sv
module sim_swallow_divider;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] ratio_word = '0;
    logic        ratio_load = 1'b0;
    logic [1:0]  test_mode = 2'b00;
    logic        p0_data = 1'b0;
    logic        div_pulse;
    logic        p0_out;
    logic        range_err;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    swallow_divider u0 (
        .clk(clk), .rst(rst), .ratio_word(ratio_word), .ratio_load(ratio_load),
        .test_mode(test_mode), .p0_data(p0_data), .div_pulse(div_pulse),
        .p0_out(p0_out), .range_err(range_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse();
        while (!div_pulse) @(negedge clk);
    endtask

    // counts cycles from one pulse to the next; checks the one-cycle width (R2)
    task automatic measure(output int n);
        wait_pulse();
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) check(!div_pulse, "R2 width", int'(div_pulse), 0);
        end while (!div_pulse);
    endtask

    task automatic apply(input int w);
        @(negedge clk);
        ratio_word = 15'(w);
        ratio_load = 1'b1;
        @(negedge clk);
        ratio_load = 1'b0;
    endtask

    task automatic t_reset();
        int n;
        repeat (3) @(negedge clk);
        check(!div_pulse, "R6 pulse in reset", int'(div_pulse), 0);
        check(!range_err, "R6 flag in reset", int'(range_err), 0);
        test_mode = 2'b01;
        #1;
        check(p0_out == 1'b0, "R6 half state", int'(p0_out), 0);
        test_mode = 2'b00;
        rst = 1'b0;
        measure(n);
        check(n == 100, "R6 reset ratio", n, 100);
    endtask

    task automatic t_ratio(input int w);
        int n;
        wait_pulse();
        apply(w);
        check(!range_err, "R3 legal word flag", int'(range_err), 0);
        measure(n);
        check(n == w, "R1 period", n, w);
    endtask

    task automatic t_deferred();
        int n;
        wait_pulse();
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 5) begin ratio_word = 15'd80; ratio_load = 1'b1; end
            if (n == 6) ratio_load = 1'b0;
        end while (!div_pulse);
        check(n == 64, "R4 cycle in progress", n, 64);
        measure(n);
        check(n == 80, "R4 next cycle", n, 80);
    endtask

    task automatic t_clamp(input int w, input int exp_n, input bit exp_err);
        int n;
        wait_pulse();
        apply(w);
        check(range_err == exp_err, "R3 flag", int'(range_err), int'(exp_err));
        measure(n);
        check(n == exp_n, "R3 clamped period", n, exp_n);
    endtask

    task automatic t_tap();
        logic prev;
        test_mode = 2'b01;
        p0_data = 1'b1;
        wait_pulse();
        @(negedge clk);
        prev = p0_out;
        for (int i = 0; i < 3; i++) begin
            repeat (20) @(negedge clk);
            check(p0_out == prev, "R5 tap holds", int'(p0_out), int'(prev));
            wait_pulse();
            check(p0_out == !prev, "R5 tap flips", int'(p0_out), int'(!prev));
            prev = p0_out;
            @(negedge clk);
        end
        for (int m = 0; m < 4; m++) begin
            if (m == 1) continue;
            test_mode = 2'(m);
            for (int d = 0; d < 2; d++) begin
                p0_data = 1'(d);
                @(negedge clk);
                check(p0_out == p0_data, "R5 passthrough", int'(p0_out), d);
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_ratio(56);     // R1 floor, A=0 M=7
        t_ratio(59);     // R1 A=3 M=7
        t_ratio(63);     // R1 A=7 M=7
        t_ratio(1000);   // R1 mid range
        t_ratio(32767);  // R1 ceiling
        t_ratio(64);     // R1 A=0 M=8
        t_deferred();
        t_clamp(10, 56, 1'b1);
        t_clamp(55, 56, 1'b1);
        t_clamp(200, 200, 1'b0);
        t_tap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule